// File: doc/BRIEF.md
# Glitch-free Clock Gate

This block passes a free-running clock through to its output while an enable input is active, and holds the output low otherwise. The enable may change at any time; it is not assumed to be synchronous to the clock. The gate switches so that every pulse at the output is a complete high phase of the input clock. No shortened pulse appears when the gate opens, and none appears when it closes.

A single gate-state register holds the decision. The register has two states, `GATE_IDLE` and `GATE_RUN`. The **ARM** transition (`GATE_IDLE` to `GATE_RUN`) happens only at a rising clock edge where the enable is high. The **HOLD** transition (`GATE_RUN` to `GATE_RUN`) happens at each rising edge that still sees the enable high. The **DROP** transition (any state to `GATE_IDLE`) is an asynchronous clear. It is active while the enable and the clock are both low, and also while power-on reset is held. The output clock is the AND of the input clock and the `GATE_RUN` indication. Because of this, a state change can only take effect at an edge where the output is already low. The block is meant for behavioural models and verification benches that need a gated clock. It does not replace a library clock-gating cell.

Top module: `clk_burst_gate`

## Requirements
- R1: While `por_n` is 0 the gate state is `GATE_IDLE` and `clk_out` is 0, whatever `enable` does. After `por_n` returns to 1, `clk_out` stays 0 until a rising edge of `clk_in` samples `enable` at 1.
- R2: When `enable` is 1 just before a rising edge of `clk_in`, `clk_out` goes high at that same edge. `clk_out` is 0 throughout the low phase that precedes the edge.
- R3: The first output pulse after the gate opens lasts exactly the high time of `clk_in`.
- R4: If `enable` falls while `clk_in` is high, the pulse in progress completes at full width. No pulse follows at the next rising edge.
- R5: The gate returns to `GATE_IDLE` asynchronously, and only while `enable` and `clk_in` are both 0. If `enable` drops and then recovers inside one low phase during a burst, no pulse is lost.
- R6: An `enable` pulse that starts and ends within a single low phase of `clk_in` produces no output pulse.
- R7: `clk_out` is never 1 while `clk_in` is 0. Every high interval of `clk_out` equals the high time of `clk_in`.
- R8: An `enable` window that covers N rising edges of `clk_in` produces exactly N output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Free-running source clock |
| enable | input | 1 | Gate request, asynchronous to `clk_in` |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| clk_out | output | 1 | Gated clock: `clk_in` AND gate state |

## Verification
The hardest situations to produce are the ones where `enable` moves close to a clock edge or inside one phase. Examples are a fall just after a rising edge, a pulse confined to a low phase, and a brief dropout between pulses of a burst. The stimulus places each `enable` transition at an exact nanosecond offset from a reference rising edge, taken from a table of windows. Each offset sits a few nanoseconds away from the edges so the outcome is unambiguous. A monitor times every output high interval, and a second one probes the output during each low phase. Together they show that truncated or stray pulses never appear.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;

    // Gate decision held by the single state register.
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_t;

endpackage

// File: rtl/cg_clear_gen.sv
`timescale 1ns/1ps
// Asynchronous clear request: gate request and clock both low (NOR),
// or power-on reset held.
module cg_clear_gen (
    input  logic clk_in,
    input  logic enable,
    input  logic por_n,
    output logic clr_async
);

    logic low_phase_off;

    always_comb begin
        low_phase_off = ~(enable | clk_in);
        clr_async     = low_phase_off | ~por_n;
    end

endmodule

// File: rtl/cg_gate_fsm.sv
`timescale 1ns/1ps
// Gate-state register. ARM and HOLD happen at rising edges of clk_in;
// DROP is the asynchronous clear.
module cg_gate_fsm
    import cg_pkg::*;
(
    input  logic clk_in,
    input  logic enable,
    input  logic clr_async,
    output logic gate_on
);

    gate_state_t state_q;
    gate_state_t state_d;

    // State register
    always_ff @(posedge clk_in or posedge clr_async) begin
        if (clr_async) begin
            state_q <= GATE_IDLE;      // DROP
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, decided at a rising edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: state_d = enable ? GATE_RUN : GATE_IDLE;  // ARM
            GATE_RUN:  state_d = enable ? GATE_RUN : GATE_IDLE;  // HOLD
        endcase
    end

    // Outputs
    always_comb begin
        gate_on = 1'b0;
        unique case (state_q)
            GATE_IDLE: gate_on = 1'b0;
            GATE_RUN:  gate_on = 1'b1;
        endcase
    end

endmodule

// File: rtl/cg_out_and.sv
`timescale 1ns/1ps
// Output stage: the clock passes only while the gate is on.
module cg_out_and (
    input  logic clk_in,
    input  logic gate_on,
    output logic clk_out
);

    always_comb begin
        clk_out = clk_in & gate_on;
    end

endmodule

// File: rtl/clk_burst_gate.sv
`timescale 1ns/1ps
module clk_burst_gate (
    input  logic clk_in,
    input  logic enable,
    input  logic por_n,
    output logic clk_out
);

    logic clr_async;
    logic gate_on;

    cg_clear_gen u_clear (
        .clk_in    (clk_in),
        .enable    (enable),
        .por_n     (por_n),
        .clr_async (clr_async)
    );

    cg_gate_fsm u_fsm (
        .clk_in    (clk_in),
        .enable    (enable),
        .clr_async (clr_async),
        .gate_on   (gate_on)
    );

    cg_out_and u_out (
        .clk_in  (clk_in),
        .gate_on (gate_on),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/cg_gate_checker.sv
`timescale 1ns/1ps
module cg_gate_checker (
    input logic clk_in,
    input logic enable,
    input logic por_n,
    input logic clk_out,
    input logic gate_on
);

    // Sampled just before a rising edge, i.e. in the low phase.
    AST_LOW_PHASE_QUIET: assert property (@(posedge clk_in) disable iff (!por_n)
        !clk_out); // R7

    // Sampled just before a falling edge, i.e. in the high phase.
    AST_HIGH_PHASE_FOLLOWS: assert property (@(negedge clk_in) disable iff (!por_n)
        clk_out == gate_on); // R2

    AST_CLEAR_IN_LOW_PHASE: assert property (@(posedge clk_in) disable iff (!por_n)
        !enable |-> !gate_on); // R5

    AST_NO_REARM_WITHOUT_REQ: assert property (@(posedge clk_in) disable iff (!por_n)
        !enable |=> !gate_on); // R4

    AST_RESET_IDLE: assert property (@(posedge clk_in)
        !por_n |-> (!gate_on && !clk_out)); // R1

endmodule

bind clk_burst_gate cg_gate_checker u_gate_checker (
    .clk_in  (clk_in),
    .enable  (enable),
    .por_n   (por_n),
    .clk_out (clk_out),
    .gate_on (gate_on)
);

// File: tb/tb_clk_burst_gate.sv
`timescale 1ns/1ps
module tb_clk_burst_gate;

    localparam int HALF_NS = 10;   // 50 MHz
    localparam int NVEC    = 8;

    // {enable on offset, enable off offset, expected pulses}, offsets in ns
    // after a reference rising edge; rising edges follow every 20 ns.
    localparam int VEC [0:NVEC-1][0:2] = '{
        '{  3,  45,  2 },   // R4: falls in high phase, pulse completes
        '{ 12,  18,  0 },   // R6: inside one low phase
        '{  5,  15,  0 },   // R5: falls in low phase before edge
        '{ 15, 105,  5 },   // R8: long window
        '{ 11,  33,  1 },   // R2: one edge covered
        '{ 19,  21,  1 },   // R3: straddles edge, falls 1 ns after it
        '{ 21,  39,  0 },   // R6: opens after edge, shuts before next
        '{  1, 201, 10 }    // R8: ten edges
    };

    logic clk_in = 1'b0;
    logic enable = 1'b0;
    logic por_n  = 1'b0;
    logic clk_out;

    int      checks      = 0;
    int      failures    = 0;
    int      pulse_count = 0;
    realtime rise_t      = 0.0;
    bit      done        = 1'b0;

    clk_burst_gate dut (
        .clk_in  (clk_in),
        .enable  (enable),
        .por_n   (por_n),
        .clk_out (clk_out)
    );

    always #(HALF_NS) clk_in = ~clk_in;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R3 R7: width of every gated pulse
    always @(posedge clk_out) rise_t = $realtime;
    always @(negedge clk_out) begin
        if (por_n && !done) begin
            pulse_count++;
            check(int'($realtime - rise_t) == HALF_NS, "R7 pulse width",
                  int'($realtime - rise_t), HALF_NS);
        end
    end

    // R7: output low inside every low phase
    always @(negedge clk_in) begin
        #3;
        if (!done) check(clk_out == 1'b0, "R7 low phase", int'(clk_out), 0);
    end

    initial begin
        // R1: reset holds output low despite enable
        enable = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk_in); #5;
            check(clk_out == 1'b0, "R1 during reset", int'(clk_out), 0);
        end
        enable = 1'b0;
        @(negedge clk_in); #2;
        por_n = 1'b1;
        repeat (2) @(posedge clk_in);
        #5;
        check(clk_out == 1'b0, "R1 after release", int'(clk_out), 0);

        // Table of enable windows
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk_in);
            pulse_count = 0;
            #(VEC[v][0]) enable = 1'b1;
            #(VEC[v][1] - VEC[v][0]) enable = 1'b0;
            #60;
            check(pulse_count == VEC[v][2], $sformatf("R8 vector %0d", v),
                  pulse_count, VEC[v][2]);
        end

        // R2: opening during low phase, first pulse at the next rising edge
        @(negedge clk_in); #2;
        enable = 1'b1;
        #5;
        check(clk_out == 1'b0, "R2 before edge", int'(clk_out), 0);
        @(posedge clk_in); #2;
        check(clk_out == 1'b1, "R2 at edge", int'(clk_out), 1);
        // R4: fall in high phase keeps current pulse, none after
        enable = 1'b0;
        #3;
        check(clk_out == 1'b1, "R4 pulse kept", int'(clk_out), 1);
        @(posedge clk_in); #5;
        check(clk_out == 1'b0, "R4 next edge off", int'(clk_out), 0);

        // R5: brief dropout within a low phase mid-burst loses no pulse
        @(posedge clk_in);
        pulse_count = 0;
        #3 enable = 1'b1;           // edges at +20,+40,+60 covered
        @(posedge clk_in);
        @(negedge clk_in); #2;
        enable = 1'b0;              // clear while low
        #3;
        enable = 1'b1;              // back before next edge
        @(posedge clk_in);
        @(posedge clk_in); #2;
        enable = 1'b0;
        #40;
        check(pulse_count == 3, "R5 dropout burst", pulse_count, 3);

        // R1: reset reapplied while enable toggles
        @(posedge clk_in);
        por_n = 1'b0;
        pulse_count = 0;
        #3 enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_in); #5;
            check(clk_out == 1'b0, "R1 reapplied", int'(clk_out), 0);
        end
        enable = 1'b0;
        @(negedge clk_in); #2;
        por_n = 1'b1;
        check(pulse_count == 0, "R1 no pulses in reset", pulse_count, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule